// File: doc/BRIEF.md
# Two-Stage SCL Timing Generator

This block produces the serial clock timing for a two-wire bus master from a fast source clock. Two cascaded counters set the pace: a sample counter divides the source clock into sample ticks, and a step counter counts those ticks to one SCL half-period. One half-period therefore lasts sample × step source cycles, and a full SCL period lasts 2 × sample × step cycles. The outputs are the SCL level and three one-cycle strobes: the first cycle of a high phase, the first cycle of a low phase, and the data sampling point in the middle of the high phase.

Two configuration words drive the counters. The normal-speed word serves standard and fast modes. The high-speed word takes over once its enable code is written. Each field holds its count minus one. Writing either word, or pulsing the soft restart, reloads the counters so that timing starts from a clean low phase. Software chooses the divider values; the block only applies them.

Top module: `sclgen_top`

## Requirements
- R1: After reset, SCL is low, no strobe is active, high-speed mode is off, and both counts are 1 (SCL period of 2 source cycles).
- R2: In normal mode the sample count minus one is taken from bits [10:8] and the step count minus one from bits [5:0] of the normal word. Each SCL phase lasts sample × step cycles and the period is 2 × sample × step.
- R3: A high-speed word with bits [1:0] = 2'b11 enables high-speed mode. Its sample count minus one sits in bits [14:12] and its step count minus one in bits [10:8]. While the mode is on, hs_active and the repeated-start request mcode_rs are both high.
- R4: Writing a high-speed word with the enable code also loads the normal word with 16'h1303 (sample 4, step 4). A later high-speed write without the enable code therefore gives 16-cycle half-periods.
- R5: Writing the normal word clears the high-speed word, so high-speed mode turns off.
- R6: A write to either word, or a soft restart, zeroes both counters and forces SCL low in the next cycle. No fall strobe is issued for that forced low phase.
- R7: rise_tick is high in exactly the first cycle of each high phase. fall_tick is high in the first cycle of each low phase that follows a high phase.
- R8: sample_tick is high in the high-phase cycle whose zero-based position equals floor(sample × step / 2).
- R9: When both words are written in the same cycle, the high-speed write takes effect and the normal data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Restart counters from a low phase |
| norm_wr | input | 1 | Write strobe for the normal timing word |
| norm_data | input | 16 | Normal timing word |
| hs_wr | input | 1 | Write strobe for the high-speed word |
| hs_data | input | 16 | High-speed timing word |
| scl_o | output | 1 | SCL level |
| rise_tick | output | 1 | First cycle of a high phase |
| fall_tick | output | 1 | First cycle of a low phase after a high phase |
| sample_tick | output | 1 | Data sampling point in the high phase |
| hs_active | output | 1 | High-speed mode in effect |
| mcode_rs | output | 1 | Repeated start forced for the master-code phase |

## Verification
The assertions assume that the write strobes and the soft restart are single-cycle pulses driven between clock edges. They also assume that a restart may land in any phase, so the edge checks exempt the cycle after a restart. The stimulus drives every strobe for one cycle on the falling edge and waits at least one full SCL period between writes. The one exception is the dual-write case, which drives both strobes on purpose. The restart cases are timed into a high phase to exercise the forced low.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
  // field positions decoded by the counters
  localparam int N_SAMP_LSB = 8;
  localparam int N_STEP_LSB = 0;
  localparam int H_SAMP_LSB = 12;
  localparam int H_STEP_LSB = 8;
  localparam logic [1:0]  HS_EN_CODE   = 2'b11;
  localparam logic [15:0] HS_NORM_FILL = 16'h1303;
endpackage

// File: rtl/sclg_cfg.sv
module sclg_cfg
  import sclg_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SAMP_W    = 3,
  parameter int STEP_W    = 6,
  parameter int HS_STEP_W = 3,
  parameter int CNT_W     = SAMP_W + STEP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm_wr,
  input  logic [REG_W-1:0] norm_data,
  input  logic             hs_wr,
  input  logic [REG_W-1:0] hs_data,
  output logic             hs_active,
  output logic [CNT_W-1:0] samp_cnt,
  output logic [CNT_W-1:0] step_cnt
);
  logic [REG_W-1:0] norm_q;
  logic [REG_W-1:0] hs_q;
  logic             unused_bits;

  function automatic logic [CNT_W-1:0] to_count(input logic [STEP_W-1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= '0;
      hs_q   <= '0;
    end else if (hs_wr) begin
      hs_q <= hs_data;
      if (hs_data[1:0] == HS_EN_CODE)
        norm_q <= REG_W'(HS_NORM_FILL);
    end else if (norm_wr) begin
      norm_q <= norm_data;
      hs_q   <= '0;
    end
  end

  assign hs_active = (hs_q[1:0] == HS_EN_CODE);

  always_comb begin
    if (hs_active) begin
      samp_cnt = to_count(STEP_W'(hs_q[H_SAMP_LSB +: SAMP_W]));
      step_cnt = to_count(STEP_W'(hs_q[H_STEP_LSB +: HS_STEP_W]));
    end else begin
      samp_cnt = to_count(STEP_W'(norm_q[N_SAMP_LSB +: SAMP_W]));
      step_cnt = to_count(norm_q[N_STEP_LSB +: STEP_W]);
    end
  end

  assign unused_bits = ^{norm_q, hs_q};
endmodule

// File: rtl/sclg_div.sv
module sclg_div #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] samp_cnt,
  input  logic [CNT_W-1:0] step_cnt,
  output logic [CNT_W-1:0] scnt,
  output logic [CNT_W-1:0] tcnt,
  output logic             phase,
  output logic             fresh,
  output logic             half_end
);
  logic samp_wrap;
  logic step_wrap;

  assign samp_wrap = (scnt == samp_cnt - CNT_W'(1));
  assign step_wrap = (tcnt == step_cnt - CNT_W'(1));
  assign half_end  = samp_wrap && step_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt  <= '0;
      tcnt  <= '0;
      phase <= 1'b0;
      fresh <= 1'b1;
    end else if (restart) begin
      scnt  <= '0;
      tcnt  <= '0;
      phase <= 1'b0;
      fresh <= 1'b1;
    end else if (samp_wrap) begin
      scnt <= '0;
      if (step_wrap) begin
        tcnt  <= '0;
        phase <= ~phase;
        fresh <= 1'b0;
      end else begin
        tcnt <= tcnt + CNT_W'(1);
      end
    end else begin
      scnt <= scnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sclg_strobes.sv
module sclg_strobes #(
  parameter int CNT_W = 10
) (
  input  logic             phase,
  input  logic             fresh,
  input  logic [CNT_W-1:0] scnt,
  input  logic [CNT_W-1:0] tcnt,
  input  logic [CNT_W-1:0] samp_cnt,
  input  logic [CNT_W-1:0] step_cnt,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             sample_tick
);
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] mid_pos;

  function automatic logic [CNT_W-1:0] phase_pos(input logic [CNT_W-1:0] t,
                                                 input logic [CNT_W-1:0] s,
                                                 input logic [CNT_W-1:0] sc);
    return t * s + sc;
  endfunction

  function automatic logic [CNT_W-1:0] half_mid(input logic [CNT_W-1:0] s,
                                                input logic [CNT_W-1:0] t);
    logic [CNT_W-1:0] h;
    h = s * t;
    return h >> 1;
  endfunction

  assign elapsed     = phase_pos(tcnt, samp_cnt, scnt);
  assign mid_pos     = half_mid(samp_cnt, step_cnt);
  assign rise_tick   = phase && (elapsed == '0);
  assign fall_tick   = !phase && !fresh && (elapsed == '0);
  assign sample_tick = phase && (elapsed == mid_pos);
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
  import sclg_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SAMP_W    = 3,
  parameter int STEP_W    = 6,
  parameter int HS_STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             norm_wr,
  input  logic [REG_W-1:0] norm_data,
  input  logic             hs_wr,
  input  logic [REG_W-1:0] hs_data,
  output logic             scl_o,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             sample_tick,
  output logic             hs_active,
  output logic             mcode_rs
);
  localparam int CNT_W = SAMP_W + STEP_W + 1;

  logic [CNT_W-1:0] samp_cnt;
  logic [CNT_W-1:0] step_cnt;
  logic [CNT_W-1:0] scnt;
  logic [CNT_W-1:0] tcnt;
  logic             phase;
  logic             fresh;
  logic             half_end;
  logic             restart;
  logic             hs_enable_wr;

  assign restart      = soft_rst || norm_wr || hs_wr;
  assign hs_enable_wr = hs_wr && (hs_data[1:0] == HS_EN_CODE);

  sclg_cfg #(
    .REG_W(REG_W), .SAMP_W(SAMP_W), .STEP_W(STEP_W),
    .HS_STEP_W(HS_STEP_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .norm_wr(norm_wr), .norm_data(norm_data),
    .hs_wr(hs_wr), .hs_data(hs_data),
    .hs_active(hs_active), .samp_cnt(samp_cnt), .step_cnt(step_cnt)
  );

  sclg_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .samp_cnt(samp_cnt), .step_cnt(step_cnt),
    .scnt(scnt), .tcnt(tcnt), .phase(phase), .fresh(fresh),
    .half_end(half_end)
  );

  sclg_strobes #(.CNT_W(CNT_W)) u_stb (
    .phase(phase), .fresh(fresh), .scnt(scnt), .tcnt(tcnt),
    .samp_cnt(samp_cnt), .step_cnt(step_cnt),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .sample_tick(sample_tick)
  );

  assign scl_o    = phase;
  assign mcode_rs = hs_active;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic norm_wr,
  input logic hs_wr,
  input logic hs_enable_wr,
  input logic half_end,
  input logic scl_o,
  input logic rise_tick,
  input logic fall_tick,
  input logic sample_tick,
  input logic hs_active
);
  p_half_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !restart) |=> (scl_o != $past(scl_o)));

  p_hs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable_wr |=> hs_active);

  p_norm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_wr && !hs_wr) |=> !hs_active);

  p_restart_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!scl_o && !fall_tick));

  p_rise_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> rise_tick);

  p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_o) && !$past(restart)) |-> fall_tick);

  p_tick_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));

  p_sample_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> scl_o);
endmodule

bind sclgen_top sclgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .norm_wr(norm_wr), .hs_wr(hs_wr), .hs_enable_wr(hs_enable_wr),
  .half_end(half_end), .scl_o(scl_o), .rise_tick(rise_tick),
  .fall_tick(fall_tick), .sample_tick(sample_tick), .hs_active(hs_active)
);

// File: tb/tb_sclgen_top.sv
module tb_sclgen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        norm_wr = 1'b0;
  logic [15:0] norm_data = '0;
  logic        hs_wr = 1'b0;
  logic [15:0] hs_data = '0;
  logic scl_o, rise_tick, fall_tick, sample_tick, hs_active, mcode_rs;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [15:0] m_norm = '0;
  logic [15:0] m_hs   = '0;
  int m_pos = 0;
  bit m_phase = 1'b0;
  bit m_fresh = 1'b1;

  always #4 clk = ~clk;

  sclgen_top dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .norm_wr(norm_wr), .norm_data(norm_data),
    .hs_wr(hs_wr), .hs_data(hs_data),
    .scl_o(scl_o), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .sample_tick(sample_tick), .hs_active(hs_active), .mcode_rs(mcode_rs)
  );

  function automatic bit m_hs_on();
    return m_hs[1:0] == 2'b11;
  endfunction

  function automatic int m_half();
    int s, t;
    if (m_hs_on()) begin
      s = int'(m_hs[14:12]) + 1;
      t = int'(m_hs[10:8]) + 1;
    end else begin
      s = int'(m_norm[10:8]) + 1;
      t = int'(m_norm[5:0]) + 1;
    end
    return s * t;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model update on the active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_norm = '0; m_hs = '0;
      m_pos = 0; m_phase = 1'b0; m_fresh = 1'b1;
    end else if (soft_rst || norm_wr || hs_wr) begin
      if (hs_wr) begin
        m_hs = hs_data;
        if (hs_data[1:0] == 2'b11) m_norm = 16'h1303;
      end else if (norm_wr) begin
        m_norm = norm_data;
        m_hs = '0;
      end
      m_pos = 0; m_phase = 1'b0; m_fresh = 1'b1;
    end else if (m_pos == m_half() - 1) begin
      m_pos = 0; m_phase = !m_phase; m_fresh = 1'b0;
    end else begin
      m_pos++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(scl_o == m_phase, "R2 scl level", scl_o, m_phase);
      check(rise_tick == (m_phase && m_pos == 0), "R7 rise_tick", rise_tick,
            int'(m_phase && m_pos == 0));
      check(fall_tick == (!m_phase && !m_fresh && m_pos == 0), "R7 fall_tick",
            fall_tick, int'(!m_phase && !m_fresh && m_pos == 0));
      check(sample_tick == (m_phase && m_pos == m_half() / 2), "R8 sample_tick",
            sample_tick, int'(m_phase && m_pos == m_half() / 2));
      check(hs_active == m_hs_on(), "R3 hs_active", hs_active, m_hs_on());
      check(mcode_rs == m_hs_on(), "R3 mcode_rs", mcode_rs, m_hs_on());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr_norm(input logic [15:0] v);
    @(negedge clk); #1; norm_wr = 1'b1; norm_data = v;
    @(negedge clk); #1; norm_wr = 1'b0;
  endtask

  task automatic wr_hs(input logic [15:0] v);
    @(negedge clk); #1; hs_wr = 1'b1; hs_data = v;
    @(negedge clk); #1; hs_wr = 1'b0;
  endtask

  task automatic measure(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!rise_tick) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rise_tick);
    check(n == exp, tag, n, exp);
  endtask

  task automatic wait_high();
    @(negedge clk);
    while (!scl_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_o == 1'b0, "R1 scl low in reset", scl_o, 0);
    check(!rise_tick && !fall_tick && !sample_tick, "R1 no strobes",
          rise_tick | fall_tick | sample_tick, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(hs_active == 1'b0, "R1 hs off", hs_active, 0);
    measure(2, "R1 default period");

    // R2: normal layout, sample 3 step 5
    wr_norm(16'h0204);
    measure(30, "R2 period 3x5");
    // R2: largest normal counts 8 x 64
    wr_norm(16'h073F);
    measure(1024, "R2 period 8x64");
    wr_norm(16'h0001);
    measure(4, "R2 period 1x2");

    // R3: high-speed, sample 2 step 3
    wr_hs(16'h1203);
    @(negedge clk);
    check(hs_active && mcode_rs, "R3 hs mode on", hs_active, 1);
    measure(12, "R3 hs period 2x3");

    // R4: disable HS, normal word now holds the fill value
    wr_hs(16'h1200);
    @(negedge clk);
    check(!hs_active, "R4 hs off", hs_active, 0);
    measure(32, "R4 filled normal period");

    // R5: normal write clears the HS word
    wr_hs(16'h7703);
    measure(128, "R3 hs period 8x8");
    wr_norm(16'h0102);
    @(negedge clk);
    check(!hs_active && !mcode_rs, "R5 hs cleared", hs_active, 0);
    measure(12, "R5 normal period 2x3");

    // R9: simultaneous writes, HS wins
    @(negedge clk); #1;
    norm_wr = 1'b1; norm_data = 16'h0000;
    hs_wr = 1'b1; hs_data = 16'h2103;
    @(negedge clk); #1; norm_wr = 1'b0; hs_wr = 1'b0;
    check(hs_active, "R9 hs wins", hs_active, 1);
    measure(12, "R9 hs period 3x2");

    // R6: soft restart during a high phase
    wr_norm(16'h0203);
    wait_high();
    #1 soft_rst = 1'b1;
    @(negedge clk); #1 soft_rst = 1'b0;
    check(!scl_o && !fall_tick, "R6 soft restart low", scl_o, 0);
    measure(24, "R6 period after restart");

    // R6: write during a high phase
    wait_high();
    @(negedge clk);
    #1 norm_wr = 1'b1; norm_data = 16'h0100;
    @(negedge clk); #1 norm_wr = 1'b0;
    check(!scl_o && !fall_tick, "R6 write restart low", scl_o, 0);
    measure(4, "R6 period 2x1");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule